// File: doc/BRIEF.md
# Addressed Three-Wire Display Command Receiver

This block sits between a host controller and a segment display driver. The host talks to it over three wires: an enable line, a serial clock and a serial data line. While enable is low the host shifts in an 8-bit device address. While enable is high it shifts in a payload. When enable drops, the receiver checks the address, the payload length and a direction bit at the end of the payload. It then copies the payload into one of two register banks. The lower bank holds display bits D1..D28 and the control fields. The upper bank holds display bits D29..D54.

All three serial lines are brought into the system clock domain through synchronizer flops. Data is taken on every rising edge of the serial clock that the synchronizer sees. Because of this it makes no difference whether the host parks the serial clock high or low between transfers. Two payload lengths are accepted, 40 bits (full layout) and 32 bits (short compatibility layout). The length alone tells the receiver which layout it has. A short lower frame switches the block into compatibility mode. In that mode the drive-mode, pin-function, oscillator and frame-rate outputs are held at fixed values, and a full-length lower frame switches the block back out again. The outputs are the 54 display bits and the decoded control fields, which drive the segment and common drivers that follow this block.

Top module: `lcdrx_top`

## Requirements
- R1: After reset, every output is zero. This covers all 54 display bits, every control output and `frame_ok_o`.
- R2: The address is taken least significant bit first, on serial clock rising edges while enable is low. Only the last 8 such bits count. A frame is accepted only if that address equals `DEV_ADDR` (default 0x44).
- R3: Payload bits are sampled on serial clock rising edges while enable is high. Bit position 0 is the first bit sent. The bit counter restarts each time enable rises, and a frame is committed only after enable falls. Results are the same whether the serial clock idles high or idles low.
- R4: A 40-bit frame whose bit 39 is 0 writes the lower bank, laid out as follows:
  - bits 0..27 go to D1..D28 (`disp_o[0]` is D1);
  - bit 28 goes to `duty_half_o`;
  - bits 31:29 go to `port_sel_o[2:0]`;
  - bits 34:32 go to `fdiv_sel_o[2:0]`;
  - bit 35 goes to `osc_ext_o`;
  - bit 36 goes to `seg_blank_o`;
  - bit 37 goes to `pwr_save_o`;
  - bit 38 is ignored.
  
  D29..D54 are left unchanged.
- R5: A 32-bit frame whose bit 31 is 1, or a 40-bit frame whose bit 39 is 1, writes payload bits 0..25 to D29..D54. Every other payload bit is ignored. D1..D28 and all control outputs are left unchanged.
- R6: A 32-bit frame whose bit 31 is 0 writes bits 0..27 to D1..D28, bit 28 to `pwr_save_o` and bit 29 to `seg_blank_o`, and puts the block into compatibility mode.
- R7: While in compatibility mode, the outputs are forced as follows:
  - `duty_half_o` reads 1;
  - `port_sel_o` reads 0;
  - `fdiv_sel_o` reads 0;
  - `osc_ext_o` reads 0.
  
  A valid 40-bit lower frame ends compatibility mode.
- R8: A frame with a wrong address, or with a payload length other than 32 or 40, changes no output.
- R9: `frame_ok_o` rises with the first accepted frame and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_en | input | 1 | Serial enable: low for address, high for payload |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| disp_o | output | 54 | Display bits, where bit n-1 is D(n) |
| duty_half_o | output | 1 | 1 selects two-phase drive, 0 selects static drive |
| port_sel_o | output | 3 | Selects which low segment pins act as plain output ports |
| fdiv_sel_o | output | 3 | Frame-rate divider code |
| osc_ext_o | output | 1 | 1 selects the external clock input, 0 selects the on-chip oscillator |
| seg_blank_o | output | 1 | 1 blanks all segments |
| pwr_save_o | output | 1 | 1 selects the low-power standby state |
| frame_ok_o | output | 1 | A valid frame has been received since reset |

## Verification
The bench builds the block with `DEV_ADDR` = 0x44 and `SYNC_STAGES` = 2. With the bench's serial half-period of three system clocks, these values place every serial edge several clocks after the previous one, so the checks cover these cases:
- both clock idle levels;
- the upper and lower banks;
- leaving compatibility mode again;
- the rejected lengths 39 and 41, one bit either side of the full length;
- address streams longer than 8 bits, where only the trailing byte must decide.

// File: rtl/lcdrx_pkg.sv
package lcdrx_pkg;
  parameter int unsigned ADDR_W    = 8;
  parameter int unsigned FULL_LEN  = 40;
  parameter int unsigned SHORT_LEN = 32;
  parameter int unsigned LO_DISP   = 28;
  parameter int unsigned HI_DISP   = 26;
  parameter int unsigned DISP_W    = LO_DISP + HI_DISP;
  parameter int unsigned LEN_W     = $clog2(FULL_LEN + 2);

  // lower-frame field positions (full layout)
  parameter int unsigned POS_DT  = 28;
  parameter int unsigned POS_P0  = 29;
  parameter int unsigned POS_FC0 = 32;
  parameter int unsigned POS_OC  = 35;
  parameter int unsigned POS_SC  = 36;
  parameter int unsigned POS_BU  = 37;
  // lower-frame field positions (short layout)
  parameter int unsigned POS_CBU = 28;
  parameter int unsigned POS_CSC = 29;

  typedef struct packed {
    logic       dt;
    logic [2:0] psel;
    logic [2:0] fdiv;
    logic       osc;
    logic       segoff;
    logic       pwr;
  } ctrl_t;
endpackage

// File: rtl/lcdrx_sync.sv
module lcdrx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lcdrx_shift.sv
module lcdrx_shift
  import lcdrx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h44
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_s,
  input  logic                ck_s,
  input  logic                din_s,
  output logic                commit_o,
  output logic                short_o,
  output logic                dir_o,
  output logic [FULL_LEN-1:0] pay_o
);
  logic                ce_q, ck_q;
  logic                ck_rise, ce_rise, ce_fall, len_full, len_short;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic [LEN_W-1:0]    cnt_q, cnt_n, last_idx;
  logic [FULL_LEN-1:0] pay_q, pay_n;
  logic                commit_n, short_q, dir_q;

  always_comb begin
    ck_rise   = ck_s & ~ck_q;
    ce_rise   = ce_s & ~ce_q;
    ce_fall   = ~ce_s & ce_q;
    len_full  = (cnt_q == LEN_W'(FULL_LEN));
    len_short = (cnt_q == LEN_W'(SHORT_LEN));
    last_idx  = cnt_q - LEN_W'(1);

    addr_n = addr_q;
    if (!ce_s && ck_rise) addr_n = {din_s, addr_q[ADDR_W-1:1]};

    cnt_n = cnt_q;
    pay_n = pay_q;
    if (ce_rise) begin
      cnt_n = '0;
    end else if (ce_s && ck_rise) begin
      if (cnt_q < LEN_W'(FULL_LEN)) pay_n[cnt_q] = din_s;
      if (cnt_q != LEN_W'(FULL_LEN + 1)) cnt_n = cnt_q + LEN_W'(1);
    end

    commit_n = ce_fall && (addr_q == DEV_ADDR) && (len_full || len_short);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q     <= 1'b0;
      ck_q     <= 1'b0;
      addr_q   <= '0;
      cnt_q    <= '0;
      pay_q    <= '0;
      commit_o <= 1'b0;
      short_q  <= 1'b0;
      dir_q    <= 1'b0;
    end else begin
      ce_q     <= ce_s;
      ck_q     <= ck_s;
      addr_q   <= addr_n;
      cnt_q    <= cnt_n;
      pay_q    <= pay_n;
      commit_o <= commit_n;
      if (ce_fall) begin
        short_q <= len_short;
        dir_q   <= pay_q[last_idx];
      end
    end
  end

  assign short_o = short_q;
  assign dir_o   = dir_q;
  assign pay_o   = pay_q;

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |=> (cnt_q == '0)); // R3
  AST_COMMIT_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> ($past(ce_q) && !$past(ce_s))); // R3
  AST_PAYLOAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_s |=> $stable(pay_q)); // R3
endmodule

// File: rtl/lcdrx_bank.sv
module lcdrx_bank
  import lcdrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic              short_i,
  input  logic              dir_i,
  input  logic [POS_BU:0]   pay_i,
  output logic [DISP_W-1:0] disp_o,
  output logic              duty_half_o,
  output logic [2:0]        port_sel_o,
  output logic [2:0]        fdiv_sel_o,
  output logic              osc_ext_o,
  output logic              seg_blank_o,
  output logic              pwr_save_o,
  output logic              frame_ok_o
);
  logic [LO_DISP-1:0] lo_q, lo_n;
  logic [HI_DISP-1:0] hi_q, hi_n;
  ctrl_t              ctl_q, ctl_n;
  logic               compat_q, compat_n;
  logic               ok_q;

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ctl_n    = ctl_q;
    compat_n = compat_q;
    if (dir_i) begin
      hi_n = pay_i[HI_DISP-1:0];
    end else begin
      lo_n = pay_i[LO_DISP-1:0];
      if (short_i) begin
        compat_n     = 1'b1;
        ctl_n.pwr    = pay_i[POS_CBU];
        ctl_n.segoff = pay_i[POS_CSC];
      end else begin
        compat_n     = 1'b0;
        ctl_n.dt     = pay_i[POS_DT];
        ctl_n.psel   = pay_i[POS_P0 +: 3];
        ctl_n.fdiv   = pay_i[POS_FC0 +: 3];
        ctl_n.osc    = pay_i[POS_OC];
        ctl_n.segoff = pay_i[POS_SC];
        ctl_n.pwr    = pay_i[POS_BU];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      ctl_q    <= '0;
      compat_q <= 1'b0;
      ok_q     <= 1'b0;
    end else if (commit_i) begin
      lo_q     <= lo_n;
      hi_q     <= hi_n;
      ctl_q    <= ctl_n;
      compat_q <= compat_n;
      ok_q     <= 1'b1;
    end
  end

  assign disp_o      = {hi_q, lo_q};
  assign duty_half_o = compat_q | ctl_q.dt;
  assign port_sel_o  = compat_q ? 3'b000 : ctl_q.psel;
  assign fdiv_sel_o  = compat_q ? 3'b000 : ctl_q.fdiv;
  assign osc_ext_o   = ~compat_q & ctl_q.osc;
  assign seg_blank_o = ctl_q.segoff;
  assign pwr_save_o  = ctl_q.pwr;
  assign frame_ok_o  = ok_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> $stable(disp_o)); // R8
  AST_UPPER_KEEPS_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && dir_i) |=> $stable(lo_q)); // R5
  AST_LOWER_KEEPS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !dir_i) |=> $stable(hi_q)); // R4
  AST_OK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |=> ok_q); // R9
endmodule

// File: rtl/lcdrx_top.sv
module lcdrx_top
  import lcdrx_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 8'h44,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic [DISP_W-1:0] disp_o,
  output logic              duty_half_o,
  output logic [2:0]        port_sel_o,
  output logic [2:0]        fdiv_sel_o,
  output logic              osc_ext_o,
  output logic              seg_blank_o,
  output logic              pwr_save_o,
  output logic              frame_ok_o
);
  logic [1:0]          rst_pipe_q;
  logic                rst_int_n;
  logic [2:0]          lines_s;
  logic                commit, short_f, dir_f;
  logic [FULL_LEN-1:0] pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  lcdrx_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({ser_dat, ser_clk, ser_en}),
    .q_o   (lines_s)
  );

  lcdrx_shift #(.DEV_ADDR(DEV_ADDR)) i_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ce_s     (lines_s[0]),
    .ck_s     (lines_s[1]),
    .din_s    (lines_s[2]),
    .commit_o (commit),
    .short_o  (short_f),
    .dir_o    (dir_f),
    .pay_o    (pay)
  );

  lcdrx_bank i_bank (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .commit_i    (commit),
    .short_i     (short_f),
    .dir_i       (dir_f),
    .pay_i       (pay[POS_BU:0]),
    .disp_o      (disp_o),
    .duty_half_o (duty_half_o),
    .port_sel_o  (port_sel_o),
    .fdiv_sel_o  (fdiv_sel_o),
    .osc_ext_o   (osc_ext_o),
    .seg_blank_o (seg_blank_o),
    .pwr_save_o  (pwr_save_o),
    .frame_ok_o  (frame_ok_o)
  );
endmodule

// File: tb/test_lcdrx_top.sv
module test_lcdrx_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic [53:0] disp_o;
  logic duty_half_o, osc_ext_o, seg_blank_o, pwr_save_o, frame_ok_o;
  logic [2:0] port_sel_o, fdiv_sel_o;

  always #5 clk = ~clk;

  lcdrx_top i_lcdrx_top (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .disp_o(disp_o), .duty_half_o(duty_half_o), .port_sel_o(port_sel_o),
    .fdiv_sel_o(fdiv_sel_o), .osc_ext_o(osc_ext_o), .seg_blank_o(seg_blank_o),
    .pwr_save_o(pwr_save_o), .frame_ok_o(frame_ok_o)
  );

  typedef struct { logic [64:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  int checks = 0, failures = 0;
  bit done = 1'b0;
  localparam int H = 3;

  // reference model state
  logic [27:0] m_lo = '0;
  logic [25:0] m_hi = '0;
  logic m_dt = 0, m_oc = 0, m_sc = 0, m_bu = 0, m_compat = 0, m_ok = 0;
  logic [2:0] m_p = '0, m_fc = '0;

  function automatic logic [64:0] model_vec();
    logic [64:0] v;
    v = {m_ok, m_compat | m_dt, m_compat ? 3'b000 : m_p, m_compat ? 3'b000 : m_fc,
         ~m_compat & m_oc, m_sc, m_bu, m_hi, m_lo};
    return v;
  endfunction

  function automatic logic [64:0] dut_vec();
    return {frame_ok_o, duty_half_o, port_sel_o, fdiv_sel_o, osc_ext_o,
            seg_blank_o, pwr_save_o, disp_o};
  endfunction

  function automatic logic [47:0] f_lo(logic [27:0] d, logic dt, logic [2:0] p,
                                       logic [2:0] fc, logic oc, logic sc, logic bu);
    logic [47:0] r = '0;
    r[27:0] = d; r[28] = dt; r[31:29] = p; r[34:32] = fc;
    r[35] = oc; r[36] = sc; r[37] = bu; r[38] = 1'b1; r[39] = 1'b0;
    return r;
  endfunction

  function automatic logic [47:0] f_up(logic [25:0] d, int len, logic [12:0] junk);
    logic [47:0] r = '0;
    r[25:0] = d; r[38:26] = junk;
    for (int i = len; i < 48; i++) r[i] = 1'b0;
    r[len-1] = 1'b1;
    return r;
  endfunction

  function automatic logic [47:0] f_sh(logic [27:0] d, logic bu, logic sc);
    logic [47:0] r = '0;
    r[27:0] = d; r[28] = bu; r[29] = sc; r[31] = 1'b0;
    return r;
  endfunction

  task automatic pause(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(logic b, bit hi_idle);
    if (hi_idle) begin
      ser_clk = 1'b0; ser_dat = b; pause(H); ser_clk = 1'b1; pause(H);
    end else begin
      ser_dat = b; pause(H); ser_clk = 1'b1; pause(H); ser_clk = 1'b0;
    end
  endtask

  task automatic model_apply(logic [15:0] ab, int na, logic [47:0] pl, int len);
    logic [7:0] a;
    a = ab[na-8 +: 8];
    if (a == 8'h44 && (len == 40 || len == 32)) begin
      m_ok = 1'b1;
      if (pl[len-1]) m_hi = pl[25:0];
      else begin
        m_lo = pl[27:0];
        if (len == 32) begin m_compat = 1'b1; m_bu = pl[28]; m_sc = pl[29]; end
        else begin
          m_compat = 1'b0; m_dt = pl[28]; m_p = pl[31:29]; m_fc = pl[34:32];
          m_oc = pl[35]; m_sc = pl[36]; m_bu = pl[37];
        end
      end
    end
  endtask

  // driver: sends one frame, updates the model, pushes the expected result
  task automatic send(logic [15:0] ab, int na, logic [47:0] pl, int len, bit hi_idle, string tag);
    exp_t e;
    ser_en = 1'b0; ser_clk = hi_idle; pause(2*H);
    for (int i = 0; i < na; i++) put_bit(ab[i], hi_idle);
    pause(H); ser_en = 1'b1; pause(H);
    for (int i = 0; i < len; i++) put_bit(pl[i], hi_idle);
    pause(H); ser_en = 1'b0;
    model_apply(ab, na, pl, len);
    e.val = model_vec(); e.tag = tag;
    exp_q.push_back(e);
    pause(24);
  endtask

  // monitor: pops expected items and compares once the result has settled
  initial begin
    exp_t e;
    logic [64:0] got;
    forever begin
      wait (exp_q.size() != 0);
      pause(14);
      e = exp_q.pop_front();
      got = dut_vec();
      checks++;
      if (got !== e.val) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", e.tag, got, e.val);
      end
    end
  end

  initial begin
    exp_t e;
    pause(5); rst_n = 1'b1; pause(5);
    e.val = model_vec(); e.tag = "R1 reset state"; exp_q.push_back(e); pause(24);

    send(16'h0044, 8, f_lo(28'h0ABCDE5, 1'b0, 3'b101, 3'b110, 1'b1, 1'b0, 1'b1), 40, 1'b0,
         "R4 R2 R9 static lower frame");
    send(16'h0044, 8, f_up(26'h2C0FFEE, 40, 13'h0000), 40, 1'b0, "R5 upper frame full length");
    send(16'h0044, 8, f_lo(28'hF00D123, 1'b1, 3'b011, 3'b001, 1'b0, 1'b1, 1'b0), 40, 1'b1,
         "R3 R4 half-duty lower, clock idle high");
    send(16'h0045, 8, f_lo(28'h1111111, 1'b0, 3'b111, 3'b111, 1'b1, 1'b1, 1'b1), 40, 1'b0,
         "R8 wrong address ignored");
    send(16'h0044, 8, f_lo(28'h2222222, 1'b0, 3'b111, 3'b111, 1'b1, 1'b0, 1'b1), 39, 1'b0,
         "R8 length 39 ignored");
    send(16'h0044, 8, f_lo(28'h3333333, 1'b0, 3'b100, 3'b010, 1'b1, 1'b0, 1'b1) | 48'h01_0000_0000_00,
         41, 1'b1, "R8 length 41 ignored");
    send(16'h0044, 8, f_sh(28'h5A5A5A5, 1'b1, 1'b0), 32, 1'b0, "R6 R7 short lower enters compat");
    send(16'h0044, 8, f_up(26'h1234567, 32, 13'h1FFF), 32, 1'b1, "R5 short upper, fixed bits ignored");
    send(16'h0113, 10, f_up(26'h0BEEF01, 40, 13'h0000), 40, 1'b0, "R2 trailing 8 address bits decide");
    send(16'h0344, 10, f_up(26'h3FFFFFF, 40, 13'h0000), 40, 1'b0, "R2 leading 0x44 then wrong tail rejected");
    send(16'h0044, 8, f_lo(28'h7654321, 1'b0, 3'b010, 3'b111, 1'b1, 1'b1, 1'b0), 40, 1'b1,
         "R7 full lower frame leaves compat");
    send(16'h0044, 8, f_up(26'h0000001, 40, 13'h1ABC), 40, 1'b1, "R5 upper frame with junk fixed bits");
    send(16'h00C4, 8, f_sh(28'h0FFFFFF, 1'b0, 1'b1), 32, 1'b0, "R8 R2 address 0xC4 rejected");

    wait (exp_q.size() == 0);
    pause(20);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule